// File: doc/BRIEF.md
# Streaming CRC-32 Engine with Programmable Seed

This block computes a 32-bit cyclic redundancy check over a stream of bytes, one byte per clock, so that a command block can carry an integrity word. The generator is x^32 + x^29 + x^18 + x^14 + x^3 + 1 (0x20044009). Bytes enter most significant bit first, nothing is bit-reversed, and the result is not inverted at the end.

A message is a run of accepted beats on a valid/ready input. The first beat carries a start flag, which seeds the checksum from the `seed_value` input, and the final beat carries an end flag. A per-beat byte-present flag lets a beat carry markers without a byte, which is how an empty message is sent. The running checksum is visible on `crc_value` after every byte, and `crc_done` pulses once when a message ends; the result then holds until the next start.

Top module: `crc32_stream_engine`

## Requirements
- R1: Each consumed byte advances the checksum by XORing the byte into bits 31:24 and then doing 8 left shifts, XORing 0x20044009 whenever the bit shifted out is 1; no reflection and no final inversion. The bytes 0x01, 0x02, 0x03, 0x04 from seed 0xFFFFFFFF give 0xF33CB7D3.
- R2: A beat with `beat_start` high uses `seed_value` as the starting checksum, and its own byte (if present) is folded in during that same beat.
- R3: `crc_value` changes only in the cycle after a consumed beat; with `beat_valid` low it holds its value.
- R4: `crc_done` is high for exactly the one cycle after the beat flagged `beat_end` is consumed; `crc_value` then holds the final checksum.
- R5: Outside a message (after reset or after an end beat), beats without `beat_start` are accepted but ignored: `crc_value` holds and `crc_done` stays low.
- R6: A beat with `beat_has_byte` low leaves the checksum unchanged; a beat with start, end and `beat_has_byte` low together yields `seed_value` on `crc_value` and pulses `crc_done`.
- R7: A start beat arriving inside a message abandons it and reseeds from `seed_value`.
- R8: While `rst` is high, `beat_ready`, `crc_done` and `crc_value` are all 0; `beat_ready` is 1 from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_value | input | 32 | Starting checksum, taken on a start beat |
| beat_valid | input | 1 | A beat is offered |
| beat_ready | output | 1 | The engine can take a beat |
| beat_data | input | 8 | Byte carried by the beat |
| beat_has_byte | input | 1 | The beat carries a byte in `beat_data` |
| beat_start | input | 1 | First beat of a message |
| beat_end | input | 1 | Final beat of a message |
| crc_value | output | 32 | Running or final checksum, registered |
| crc_done | output | 1 | One-cycle pulse after the end beat is consumed |

## Verification
The hardest situation to reach is a beat that lands while the engine sits between messages or inside one with an unexpected flag combination: a stray non-start beat after completion, a byte-less beat in mid-message, a restart before the end beat, or a start-and-end beat with no byte. Random messages with random seeds, lengths and idle gaps are mixed with directed sequences that place exactly these beats right after a completion and in the middle of a message, and every byte's running checksum is compared with a bit-serial model in the bench.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
  localparam int unsigned CRC_W   = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam logic [CRC_W-1:0] GEN_POLY = 32'h2004_4009;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic take_seed;
    logic fold_byte;
    logic consume;
  } step_ctl_t;
endpackage

// File: rtl/crc_shift_stage.sv
module crc_shift_stage #(
  parameter int unsigned       W    = 32,
  parameter logic [W-1:0]      POLY = '0
) (
  input  logic [W-1:0] reg_in,
  output logic [W-1:0] reg_out
);
  logic [W-1:0] shifted;

  always_comb begin
    shifted = {reg_in[W-2:0], 1'b0};
    reg_out = reg_in[W-1] ? (shifted ^ POLY) : shifted;
  end
endmodule

// File: rtl/crc_byte_update.sv
module crc_byte_update #(
  parameter int unsigned  W    = 32,
  parameter int unsigned  D    = 8,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic [W-1:0] crc_in,
  input  logic [D-1:0] data_in,
  output logic [W-1:0] crc_out
);
  localparam int unsigned TOP = W - D;

  logic [W-1:0] chain [0:D];

  always_comb begin
    chain[0] = crc_in ^ {data_in, {TOP{1'b0}}};
  end

  for (genvar s = 0; s < D; s++) begin : g_stage
    crc_shift_stage #(.W(W), .POLY(POLY)) u_stage (
      .reg_in  (chain[s]),
      .reg_out (chain[s+1])
    );
  end

  always_comb crc_out = chain[D];

  // A zero checksum with a zero byte stays zero (linearity of the update).
  always_comb begin
    if (crc_in == '0 && data_in == '0)
      a_r1_zero_fixed: assert (crc_out == '0);
  end
endmodule

// File: rtl/crc_beat_ctrl.sv
module crc_beat_ctrl
  import crc32_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      beat_valid,
  input  logic      beat_has_byte,
  input  logic      beat_start,
  input  logic      beat_end,
  output logic      ready,
  output logic      in_msg,
  output logic      done,
  output step_ctl_t ctl
);
  logic ready_q, busy_q, done_q;
  logic accept;

  always_comb begin
    accept        = beat_valid & ready_q;
    ctl.consume   = accept & (beat_start | busy_q);
    ctl.take_seed = beat_start;
    ctl.fold_byte = beat_has_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= ctl.consume & beat_end;
      if (ctl.consume) begin
        if (beat_end)        busy_q <= 1'b0;
        else if (beat_start) busy_q <= 1'b1;
      end
    end
  end

  assign ready  = ready_q;
  assign in_msg = busy_q;
  assign done   = done_q;

  // R4: completion always returns the engine to the idle state.
  a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  // R5: a stray beat between messages never completes anything.
  a_r5_idle_no_done: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && ready_q && !beat_start && !busy_q) |=> !done_q);

  // R8: ready is low while reset is held.
  a_r8_ready_reset: assert property (@(posedge clk)
    rst |=> (!ready_q || !rst));
endmodule

// File: rtl/crc32_stream_engine.sv
module crc32_stream_engine
  import crc32_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] seed_value,
  input  logic        beat_valid,
  output logic        beat_ready,
  input  logic [7:0]  beat_data,
  input  logic        beat_has_byte,
  input  logic        beat_start,
  input  logic        beat_end,
  output logic [31:0] crc_value,
  output logic        crc_done
);
  step_ctl_t ctl;
  logic      in_msg;
  crc_t      crc_q, base, stepped, next_crc;

  crc_beat_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .beat_valid    (beat_valid),
    .beat_has_byte (beat_has_byte),
    .beat_start    (beat_start),
    .beat_end      (beat_end),
    .ready         (beat_ready),
    .in_msg        (in_msg),
    .done          (crc_done),
    .ctl           (ctl)
  );

  always_comb base = ctl.take_seed ? crc_t'(seed_value) : crc_q;

  crc_byte_update #(.W(CRC_W), .D(BYTE_W), .POLY(GEN_POLY)) u_update (
    .crc_in  (base),
    .data_in (byte_t'(beat_data)),
    .crc_out (stepped)
  );

  always_comb next_crc = ctl.fold_byte ? stepped : base;

  always_ff @(posedge clk) begin
    if (rst)              crc_q <= '0;
    else if (ctl.consume) crc_q <= next_crc;
  end

  assign crc_value = crc_q;

  // R3: no offered beat, no change.
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !beat_valid |=> $stable(crc_value));

  // R5: beats between messages without a start leave the result alone.
  a_r5_stray_hold: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && !beat_start && !in_msg) |=> $stable(crc_value));

  // R6: an empty start beat produces the seed.
  a_r6_empty_seed: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && beat_start && !beat_has_byte)
      |=> crc_value == $past(seed_value));

  // R6: a byte-less beat inside a message keeps the checksum.
  a_r6_nobyte_hold: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && !beat_start && !beat_has_byte) |=> $stable(crc_value));
endmodule

// File: tb/sim_crc32_stream_engine.sv
module sim_crc32_stream_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] POLY = 32'h2004_4009;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] seed_value = '0;
  logic        beat_valid = 1'b0;
  logic        beat_ready;
  logic [7:0]  beat_data = '0;
  logic        beat_has_byte = 1'b0;
  logic        beat_start = 1'b0;
  logic        beat_end = 1'b0;
  logic [31:0] crc_value;
  logic        crc_done;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc32_stream_engine u0 (
    .clk(clk), .rst(rst), .seed_value(seed_value),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
    .beat_has_byte(beat_has_byte), .beat_start(beat_start), .beat_end(beat_end),
    .crc_value(crc_value), .crc_done(crc_done)
  );

  function automatic logic [31:0] ref_step(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      if (r[31] ^ b[k]) r = (r << 1) ^ POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic v, logic s, logic e, logic hb, logic [7:0] d);
    beat_valid = v; beat_start = s; beat_end = e; beat_has_byte = hb; beat_data = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  logic [7:0] msg [0:31];

  // Sends msg[0..len-1] (len >= 1), checks every step; returns final checksum.
  task automatic send_msg(logic [31:0] seed, int len, bit gaps, output logic [31:0] result);
    logic [31:0] ref_c;
    seed_value = seed;
    ref_c = seed;
    for (int i = 0; i < len; i++) begin
      drive(1'b1, i == 0, i == len - 1, 1'b1, msg[i]);
      tick();
      ref_c = ref_step(ref_c, msg[i]);
      chk32("R1 running checksum", crc_value, ref_c);
      chk1("R4 done timing", crc_done, i == len - 1);
      if (gaps && i != len - 1 && ($urandom % 3 == 0)) begin
        idle();
        tick();
        chk32("R3 hold with valid low", crc_value, ref_c);
      end
    end
    idle();
    tick();
    chk1("R4 done single cycle", crc_done, 1'b0);
    chk32("R4 result holds", crc_value, ref_c);
    result = ref_c;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] res, ref_c;
    void'($urandom(32'd20240611));
    @(negedge clk);
    tick();
    chk1("R8 ready in reset", beat_ready, 1'b0);
    chk1("R8 done in reset", crc_done, 1'b0);
    chk32("R8 crc in reset", crc_value, 32'h0);
    rst = 1'b0;
    tick();
    chk1("R8 ready after reset", beat_ready, 1'b1);

    // R5: stray beat before any message
    seed_value = 32'h1234_5678;
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hA5);
    tick();
    chk32("R5 stray beat ignored", crc_value, 32'h0);
    chk1("R5 stray no done", crc_done, 1'b0);
    idle();

    // R1 known vector
    msg[0] = 8'h01; msg[1] = 8'h02; msg[2] = 8'h03; msg[3] = 8'h04;
    send_msg(32'hFFFF_FFFF, 4, 1'b0, res);
    chk32("R1 known vector", res, 32'hF33C_B7D3);

    // R5 after completion
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h77);
    tick();
    chk32("R5 beat after done ignored", crc_value, 32'hF33C_B7D3);
    chk1("R5 no done after stray", crc_done, 1'b0);
    idle();

    // R6 zero-length message
    seed_value = 32'hCAFE_F00D;
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h5A);
    tick();
    chk32("R6 empty message gives seed", crc_value, 32'hCAFE_F00D);
    chk1("R6 empty message done", crc_done, 1'b1);
    idle();
    tick();
    chk1("R4 done drops", crc_done, 1'b0);

    // R2 + R6: start beat with byte, then byte-less middle beat, then end
    seed_value = 32'h0BAD_BEEF;
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h3C);
    tick();
    ref_c = ref_step(32'h0BAD_BEEF, 8'h3C);
    chk32("R2 seed plus first byte", crc_value, ref_c);
    seed_value = 32'h1111_1111;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    tick();
    chk32("R6 byte-less beat holds", crc_value, ref_c);
    chk1("R6 no done mid message", crc_done, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hC3);
    tick();
    ref_c = ref_step(ref_c, 8'hC3);
    chk32("R6 message continues", crc_value, ref_c);
    chk1("R4 done after end", crc_done, 1'b1);
    idle();
    tick();

    // R7 restart inside a message
    seed_value = 32'hFFFF_FFFF;
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h99);
    tick();
    seed_value = 32'h0000_0001;
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h42);
    tick();
    ref_c = ref_step(32'h0000_0001, 8'h42);
    chk32("R7 restart reseeds", crc_value, ref_c);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'h24);
    tick();
    ref_c = ref_step(ref_c, 8'h24);
    chk32("R7 restarted result", crc_value, ref_c);
    chk1("R7 done after restart", crc_done, 1'b1);
    idle();
    tick();

    // Random messages (R1, R3, R4)
    for (int m = 0; m < 300; m++) begin
      int len;
      len = 1 + ($urandom % 24);
      for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
      send_msg($urandom, len, 1'b1, res);
      if ($urandom % 4 == 0) begin
        drive(1'b1, 1'b0, ($urandom % 2) == 1, 1'b1, 8'($urandom));
        tick();
        chk32("R5 random stray beat", crc_value, res);
        idle();
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule